// File: doc/BRIEF.md
# Downstream Port Status Indicator Controller

This block lights a green and an amber indicator for each downstream port of a hub. Each port has a 2-bit selector that the hub's request logic writes through a small write strobe interface. While a port's selector is 00, the port's lights follow its live status inputs: connected, enabled, over-current and error. Any other selector value lights the port in a fixed colour, or turns it off, whatever its status is.

Two board-level conditions take priority over what a port would otherwise show. During global suspend every indicator is dark, which saves power. When a configuration EEPROM is present, the amber outputs of the lowest ports stay low, because their pins double as EEPROM access lines and a pulse on them could corrupt the memory. Error indication blinks at a rate set by a parameter, from one prescaler that all ports share.

Top module: `port_led_ctl`

## Requirements
- R1: After reset every selector holds 00 (automatic), so every output follows the port status inputs straight away.
- R2: In automatic mode a port that is not connected and not over-current shows neither colour.
- R3: In automatic mode a port that is connected and enabled, with no error and no over-current, shows green only.
- R4: In automatic mode over-current on a port shows steady amber and no green, whether the port is connected or not.
- R5: In automatic mode a connected port with error and no over-current shows no green and blinks amber, high for BLINK_HALF cycles and then low for BLINK_HALF cycles.
- R6: A write (wr_en high at a rising edge) stores wr_sel into the selector of port wr_port from the next cycle on, and leaves the other ports unchanged. Selector 01 gives steady amber, 10 steady green and 11 off, and the port's status inputs then have no effect. Writing 00 returns the port to automatic mode.
- R7: While suspend is high both outputs of every port are low in every mode. When suspend falls the previous display comes back.
- R8: While eeprom_present is high amber stays low on ports 0 to SHARED-1, with SHARED = 2 by default. Their green outputs and all outputs of the other ports are not affected.
- R9: A port never drives green and amber high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Selector write strobe |
| wr_port | input | $clog2(NPORT) | Port index for the write |
| wr_sel | input | 2 | Selector value: 00 auto, 01 amber, 10 green, 11 off |
| connected | input | NPORT | A device is attached, one bit per port |
| enabled | input | NPORT | The port is enabled |
| overcur | input | NPORT | Over-current on the port |
| err | input | NPORT | Port error condition |
| suspend | input | 1 | The hub is globally suspended |
| eeprom_present | input | 1 | A valid configuration EEPROM claims the shared pins |
| green | output | NPORT | Green indicator per port |
| amber | output | NPORT | Amber indicator per port |

## Verification
The automatic mode is driven with status patterns that separate the priorities. Over-current is applied with and without connection, which shows that it outranks the connection test. Error is applied together with enable, which shows that a blinking amber replaces green. The blink is then timed edge to edge, to confirm its high and low lengths. Manual selectors are written to one port while conflicting status is applied, which shows both that status is ignored in manual mode and that neighbouring ports keep their own settings. Suspend and EEPROM presence are applied over mixed displays, so the forced-off outputs can be told apart from the outputs that must remain lit.

// File: rtl/port_led_ctl.sv
`timescale 1ns/1ps
module port_led_ctl #(
  parameter int NPORT      = 4,
  parameter int SHARED     = 2,
  parameter int BLINK_HALF = 1_500_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NPORT)-1:0] wr_port,
  input  logic [1:0]               wr_sel,
  input  logic [NPORT-1:0]         connected,
  input  logic [NPORT-1:0]         enabled,
  input  logic [NPORT-1:0]         overcur,
  input  logic [NPORT-1:0]         err,
  input  logic                     suspend,
  input  logic                     eeprom_present,
  output logic [NPORT-1:0]         green,
  output logic [NPORT-1:0]         amber
);
  localparam int CW = $clog2(BLINK_HALF + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(BLINK_HALF - 1);

  logic [CW-1:0]      cnt;
  logic               phase;
  logic [2*NPORT-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (cnt == CNT_LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= '0;
    else if (wr_en && (int'(wr_port) < NPORT))
      sel_q[{wr_port, 1'b0} +: 2] <= wr_sel;
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    localparam bit PIN_SHARED = (i < SHARED);
    logic [1:0] s;
    logic       g_auto, a_auto, g_raw, a_raw;

    assign s      = sel_q[2*i +: 2];
    assign a_auto = overcur[i] | (connected[i] & err[i] & phase);
    assign g_auto = connected[i] & enabled[i] & ~err[i] & ~overcur[i];

    always_comb begin
      case (s)
        2'b00:   begin g_raw = g_auto; a_raw = a_auto; end
        2'b01:   begin g_raw = 1'b0;   a_raw = 1'b1;   end
        2'b10:   begin g_raw = 1'b1;   a_raw = 1'b0;   end
        default: begin g_raw = 1'b0;   a_raw = 1'b0;   end
      endcase
    end

    assign green[i] = ~suspend & g_raw;
    assign amber[i] = ~suspend & ~(eeprom_present & PIN_SHARED) & a_raw;
  end
endmodule

// File: rtl/port_led_ctl_chk.sv
`timescale 1ns/1ps
module port_led_ctl_chk #(
  parameter int NPORT  = 4,
  parameter int SHARED = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [$clog2(NPORT)-1:0] wr_port,
  input logic [1:0]               wr_sel,
  input logic [2*NPORT-1:0]       sel_q,
  input logic [NPORT-1:0]         overcur,
  input logic                     suspend,
  input logic                     eeprom_present,
  input logic [NPORT-1:0]         green,
  input logic [NPORT-1:0]         amber
);
  // R7
  suspend_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> (green == '0 && amber == '0));

  // R8
  shared_amber_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eeprom_present |-> (amber[SHARED-1:0] == '0));

  // R9
  one_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (green & amber) == '0);

  // R6
  sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_port) < NPORT) |=> (sel_q[{$past(wr_port), 1'b0} +: 2] == $past(wr_sel)));

  for (genvar i = 0; i < NPORT; i++) begin : g_oc
    // R4
    overcur_amber_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[2*i +: 2] == 2'b00 && overcur[i] && !suspend && !(eeprom_present && i < SHARED))
        |-> (amber[i] && !green[i]));
  end
endmodule

bind port_led_ctl port_led_ctl_chk #(.NPORT(NPORT), .SHARED(SHARED)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_sel(wr_sel),
  .sel_q(sel_q), .overcur(overcur), .suspend(suspend),
  .eeprom_present(eeprom_present), .green(green), .amber(amber)
);

// File: tb/port_led_ctl_tb.sv
`timescale 1ns/1ps
module port_led_ctl_tb;
  localparam int NPORT = 4;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_port = '0;
  logic [1:0] wr_sel = '0;
  logic [NPORT-1:0] connected = '0, enabled = '0, overcur = '0, err = '0;
  logic suspend = 1'b0, eeprom_present = 1'b0;
  logic [NPORT-1:0] green, amber;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  port_led_ctl #(.NPORT(NPORT), .SHARED(2), .BLINK_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_sel(wr_sel),
    .connected(connected), .enabled(enabled), .overcur(overcur), .err(err),
    .suspend(suspend), .eeprom_present(eeprom_present), .green(green), .amber(amber)
  );

  task automatic chk(input string tag, input logic [NPORT-1:0] got, input logic [NPORT-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic wsel(input int p, input logic [1:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_port = 2'(p); wr_sel = s;
    @(negedge clk);
    wr_en = 1'b0; #1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R1 green dark after reset", green, 4'b0000);
    chk("R1 amber dark after reset", amber, 4'b0000);
    connected = 4'b0001; enabled = 4'b0001;
    settle();
    chk("R1 auto at reset green", green, 4'b0001);
  endtask

  task automatic t_auto();
    connected = 4'b0110; enabled = 4'b1110; overcur = '0; err = '0;
    settle();
    chk("R3 green on connected+enabled", green, 4'b0110);
    chk("R2 amber off", amber, 4'b0000);
    chk("R2 unconnected port3 dark", green[3] | amber[3], 1'b0);
  endtask

  task automatic t_overcur();
    connected = 4'b0100; enabled = 4'b0100; overcur = 4'b1100;
    settle();
    chk("R4 amber on overcur regardless of connect", amber, 4'b1100);
    chk("R4 green off on overcur", green, 4'b0000);
    overcur = '0;
    settle();
  endtask

  task automatic t_blink();
    int n;
    connected = 4'b0100; enabled = 4'b0100; err = 4'b0100;
    settle();
    chk("R5 green off on error", green, 4'b0000);
    n = 0;
    while (amber[2] !== 1'b0 && n < 20) begin n++; settle(); end
    n = 0;
    while (amber[2] !== 1'b1 && n < 20) begin n++; settle(); end
    n = 0;
    while (amber[2] === 1'b1 && n < 20) begin n++; settle(); end
    chk("R5 blink high length", 4'(n), 4'(HALF));
    n = 0;
    while (amber[2] === 1'b0 && n < 20) begin n++; settle(); end
    chk("R5 blink low length", 4'(n), 4'(HALF));
    err = '0;
    settle();
  endtask

  task automatic t_manual();
    connected = 4'b1111; enabled = 4'b1111; overcur = '0; err = '0;
    wsel(3, 2'b01);
    chk("R6 sel01 amber", amber, 4'b1000);
    chk("R6 sel01 green others", green, 4'b0111);
    wsel(0, 2'b11);
    chk("R6 sel11 off, port3 kept", {green, amber}, {4'b0110, 4'b1000});
    overcur = 4'b0001;
    wsel(1, 2'b10);
    settle();
    chk("R6 status ignored in manual", amber, 4'b1000);
    chk("R6 sel10 green", green, 4'b0110);
    overcur = '0; enabled = 4'b0000;
    settle();
    chk("R6 manual green held without enable", green, 4'b0010);
    wsel(1, 2'b00);
    chk("R6 back to auto", green, 4'b0000);
    enabled = 4'b1111;
    wsel(0, 2'b00);
    wsel(3, 2'b00);
    chk("R6 all auto restored", green, 4'b1111);
  endtask

  task automatic t_suspend();
    connected = 4'b1111; enabled = 4'b0011; overcur = 4'b0100;
    wsel(3, 2'b10);
    suspend = 1'b1;
    settle();
    chk("R7 suspend green dark", green, 4'b0000);
    chk("R7 suspend amber dark", amber, 4'b0000);
    suspend = 1'b0;
    settle();
    chk("R7 resume green", green, 4'b1011);
    chk("R7 resume amber", amber, 4'b0100);
    wsel(3, 2'b00);
    overcur = '0;
  endtask

  task automatic t_eeprom();
    connected = 4'b1111; enabled = 4'b0010; overcur = 4'b0000;
    wsel(0, 2'b01);
    wsel(2, 2'b01);
    overcur = 4'b1000;
    eeprom_present = 1'b1;
    settle();
    chk("R8 shared amber off, others kept", amber, 4'b1100);
    chk("R8 green unaffected", green, 4'b0010);
    eeprom_present = 1'b0;
    settle();
    chk("R8 amber back when eeprom gone", amber, 4'b1101);
    chk("R9 no port both colours", green & amber, 4'b0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_auto();
    t_overcur();
    t_blink();
    t_manual();
    t_suspend();
    t_eeprom();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule